// File: doc/BRIEF.md
# AEGIS-128 Streaming Cipher Block Unit

This unit runs the message phase of the AEGIS-128 authenticated cipher, one 16-byte block at a time. It holds a state of five 128-bit words. For each accepted block it forms a keystream word from the state as it stands before that block. It combines the input with the keystream to give the output block. It then folds the plaintext back into the state through five parallel AES rounds. One mode bit selects the direction. In encrypt mode the input is plaintext. In decrypt mode the input is ciphertext, and the plaintext is recovered before it is folded into the state.

A caller sends full blocks first. After them comes at most one short tail block, whose byte count lies between 1 and 15. The unit sets byte lanes beyond the count to zero in both the output and the word folded into the state. This makes a short tail give the same final state in either direction. The starting state is written through a load port, and the live state can be read at all times from a state output port. This lets the caller chain the unit to the setup and finishing steps, which are done elsewhere.

Top module: `aegis_stream_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` is 0, `in_ready` is 1 and `st_cur` is all zero.
- R2: When `st_load` is high and no block is in flight, `st_cur` equals `st_init` one cycle later. `in_ready` is 0 in every cycle in which `st_load` is high.
- R3: State word i is `st_cur[128*i+127:128*i]`, and byte k of a word is its bits `[8*k+7:8*k]`. The keystream for a block is w1 XOR (w2 AND w3) XOR w4, taken from the state present at the edge where the block is accepted.
- R4: In encrypt mode (`in_decrypt`=0), the cycle after acceptance shows `out_valid`=1 and `out_data` = plaintext XOR keystream over the valid lanes.
- R5: In decrypt mode (`in_decrypt`=1), the cycle after acceptance shows `out_valid`=1 and `out_data` = ciphertext XOR keystream over the valid lanes.
- R6: Two cycles after acceptance the state is the update of the old state with absorbed word m. Let A(x) be MixColumns(ShiftRows(SubBytes(x))), where column c holds bytes 4c..4c+3 and byte 4c+r sits in row r. The new w0 is w0^A(w4)^m, and for i=1..4 the new wi is wi^A(w(i-1)). `st_cur` does not change in the cycle in which `out_valid` is 1.
- R7: In encrypt mode the absorbed word is the input with lanes at or beyond the count forced to zero. Input bytes in those lanes have no effect.
- R8: In decrypt mode the absorbed word is the recovered plaintext with lanes at or beyond the count forced to zero. Ciphertext bytes in those lanes have no effect on the output or on the state.
- R9: Output lanes k >= count are zero. `out_nbytes` gives the count in force, and an `in_nbytes` of 0 or above 16 is treated as 16.
- R10: `in_ready` is 0 in the cycle after a block is accepted, so at most one block is accepted every two cycles.
- R11: Starting from the same state, decrypting the ciphertext of a 1 to 48 byte message returns that message and leaves the same final state as the encryption did.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_load | input | 1 | Write `st_init` into the state |
| st_init | input | 640 | Starting state, word i at bits [128i+127:128i] |
| in_valid | input | 1 | A block is offered |
| in_ready | output | 1 | The unit accepts a block this cycle |
| in_decrypt | input | 1 | 0 = encrypt, 1 = decrypt |
| in_data | input | 128 | Input block, byte k at bits [8k+7:8k] |
| in_nbytes | input | 5 | Valid byte count of the block (1..16) |
| out_valid | output | 1 | Output block is present |
| out_data | output | 128 | Transformed block, invalid lanes zero |
| out_nbytes | output | 5 | Count in force for the output block |
| st_cur | output | 640 | Current state |

## Verification
An output block is due at the first falling edge after the accepting rising edge. The state that includes that block is due one rising edge later, when `in_ready` has gone high again. The bench's driver pushes the expected block and count into a queue before it raises `in_valid`. A monitor compares each block on the falling edge where `out_valid` is high, and an output with no queued entry counts as a failure. The driver checks the state and `in_ready` only after it has seen `in_ready` high at a falling edge. At that point the two-cycle update is complete.

// File: rtl/aegis_pkg.sv
package aegis_pkg;

    localparam int BLK_BYTES  = 16;
    localparam int BLK_BITS   = BLK_BYTES * 8;
    localparam int NUM_WORDS  = 5;
    localparam int ST_BITS    = NUM_WORDS * BLK_BITS;
    localparam int CNT_W      = $clog2(BLK_BYTES) + 1;

    typedef logic [7:0]          byte_t;
    typedef logic [BLK_BITS-1:0] word_t;
    typedef logic [CNT_W-1:0]    cnt_t;

    typedef struct packed {
        word_t w4;
        word_t w3;
        word_t w2;
        word_t w1;
        word_t w0;
    } state_t;

    typedef enum logic { MODE_ENC = 1'b0, MODE_DEC = 1'b1 } mode_e;
    typedef enum logic { PH_IDLE = 1'b0, PH_ABSORB = 1'b1 } phase_e;

    function automatic byte_t gf_x2(byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic byte_t gf_x3(byte_t a);
        return gf_x2(a) ^ a;
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_x2(sh);
        end
        return acc;
    endfunction

    // multiplicative inverse as a^254 (zero maps to zero)
    function automatic byte_t gf_inv(byte_t a);
        byte_t p2, p3, p12, p15, p240;
        p2   = gf_mul(a, a);
        p3   = gf_mul(p2, a);
        p12  = gf_mul(p3, p3);
        p12  = gf_mul(p12, p12);
        p15  = gf_mul(p12, p3);
        p240 = gf_mul(p15, p15);
        p240 = gf_mul(p240, p240);
        p240 = gf_mul(p240, p240);
        p240 = gf_mul(p240, p240);
        return gf_mul(gf_mul(p240, p12), p2);
    endfunction

    function automatic byte_t rotl8(byte_t a, int n);
        return byte_t'((a << n) | (a >> (8 - n)));
    endfunction

    function automatic byte_t sbox_affine(byte_t b);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    function automatic cnt_t eff_count(cnt_t n);
        return (n == '0 || n > cnt_t'(BLK_BYTES)) ? cnt_t'(BLK_BYTES) : n;
    endfunction

    function automatic word_t lane_mask(cnt_t n);
        word_t m;
        for (int k = 0; k < BLK_BYTES; k++)
            m[8*k +: 8] = (cnt_t'(k) < n) ? 8'hFF : 8'h00;
        return m;
    endfunction

endpackage

// File: rtl/aegis_sbox.sv
module aegis_sbox
    import aegis_pkg::*;
(
    input  byte_t a,
    output byte_t y
);
    byte_t inv;

    always_comb begin
        inv = gf_inv(a);
        y   = sbox_affine(inv);
    end
endmodule

// File: rtl/aegis_aes_round.sv
module aegis_aes_round
    import aegis_pkg::*;
(
    input  word_t din,
    output word_t dout
);
    localparam int COLS = BLK_BYTES / 4;

    word_t sub_w;
    word_t shf_w;

    for (genvar k = 0; k < BLK_BYTES; k++) begin : g_sub
        aegis_sbox u_sbox (
            .a (din[8*k +: 8]),
            .y (sub_w[8*k +: 8])
        );
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        for (genvar r = 0; r < 4; r++) begin : g_row
            assign shf_w[8*(4*c+r) +: 8] = sub_w[8*(4*((c+r)%COLS)+r) +: 8];
        end

        byte_t a0, a1, a2, a3;
        assign a0 = shf_w[8*(4*c)   +: 8];
        assign a1 = shf_w[8*(4*c+1) +: 8];
        assign a2 = shf_w[8*(4*c+2) +: 8];
        assign a3 = shf_w[8*(4*c+3) +: 8];

        assign dout[8*(4*c)   +: 8] = gf_x2(a0) ^ gf_x3(a1) ^ a2 ^ a3;
        assign dout[8*(4*c+1) +: 8] = a0 ^ gf_x2(a1) ^ gf_x3(a2) ^ a3;
        assign dout[8*(4*c+2) +: 8] = a0 ^ a1 ^ gf_x2(a2) ^ gf_x3(a3);
        assign dout[8*(4*c+3) +: 8] = gf_x3(a0) ^ a1 ^ a2 ^ gf_x2(a3);
    end
endmodule

// File: rtl/aegis_state_update.sv
module aegis_state_update
    import aegis_pkg::*;
(
    input  state_t st_in,
    input  word_t  absorb,
    output state_t st_out
);
    word_t words_in  [NUM_WORDS];
    word_t rounds    [NUM_WORDS];

    assign words_in[0] = st_in.w0;
    assign words_in[1] = st_in.w1;
    assign words_in[2] = st_in.w2;
    assign words_in[3] = st_in.w3;
    assign words_in[4] = st_in.w4;

    // rounds[i] = A(word i-1), with word 0 fed by the last word
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_rnd
        aegis_aes_round u_round (
            .din  (words_in[(i + NUM_WORDS - 1) % NUM_WORDS]),
            .dout (rounds[i])
        );
    end

    assign st_out.w0 = st_in.w0 ^ rounds[0] ^ absorb;
    assign st_out.w1 = st_in.w1 ^ rounds[1];
    assign st_out.w2 = st_in.w2 ^ rounds[2];
    assign st_out.w3 = st_in.w3 ^ rounds[3];
    assign st_out.w4 = st_in.w4 ^ rounds[4];
endmodule

// File: rtl/aegis_block_xform.sv
module aegis_block_xform
    import aegis_pkg::*;
(
    input  state_t st,
    input  mode_e  mode,
    input  word_t  din,
    input  cnt_t   nbytes,
    output word_t  dout,
    output word_t  absorb,
    output cnt_t   cnt
);
    word_t keystream;
    word_t mask;
    word_t mixed;

    always_comb begin
        keystream = st.w1 ^ (st.w2 & st.w3) ^ st.w4;
        cnt       = eff_count(nbytes);
        mask      = lane_mask(cnt);
        mixed     = (din ^ keystream) & mask;
        dout      = mixed;
        absorb    = (mode == MODE_DEC) ? mixed : (din & mask);
    end
endmodule

// File: rtl/aegis_stream_unit.sv
module aegis_stream_unit
    import aegis_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                st_load,
    input  logic [ST_BITS-1:0]  st_init,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic                in_decrypt,
    input  logic [BLK_BITS-1:0] in_data,
    input  logic [CNT_W-1:0]    in_nbytes,
    output logic                out_valid,
    output logic [BLK_BITS-1:0] out_data,
    output logic [CNT_W-1:0]    out_nbytes,
    output logic [ST_BITS-1:0]  st_cur
);
    phase_e phase_q;
    state_t st_q;
    state_t st_upd;
    word_t  absorb_q;
    word_t  x_dout;
    word_t  x_absorb;
    cnt_t   x_cnt;
    logic   busy;
    logic   accept;

    assign busy     = (phase_q == PH_ABSORB);
    assign in_ready = !busy && !st_load;
    assign accept   = in_valid && in_ready;
    assign st_cur   = st_q;

    aegis_block_xform u_xform (
        .st     (st_q),
        .mode   (mode_e'(in_decrypt)),
        .din    (in_data),
        .nbytes (in_nbytes),
        .dout   (x_dout),
        .absorb (x_absorb),
        .cnt    (x_cnt)
    );

    aegis_state_update u_update (
        .st_in  (st_q),
        .absorb (absorb_q),
        .st_out (st_upd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            st_q       <= '0;
            absorb_q   <= '0;
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_nbytes <= '0;
        end else begin
            out_valid <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (st_load) begin
                        st_q <= state_t'(st_init);
                    end else if (accept) begin
                        out_valid  <= 1'b1;
                        out_data   <= x_dout;
                        out_nbytes <= x_cnt;
                        absorb_q   <= x_absorb;
                        phase_q    <= PH_ABSORB;
                    end
                end
                PH_ABSORB: begin
                    st_q    <= st_upd;
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/aegis_stream_unit_chk.sv
module aegis_stream_unit_chk
    import aegis_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                st_load,
    input logic [ST_BITS-1:0]  st_init,
    input logic                in_valid,
    input logic                in_ready,
    input logic                busy,
    input logic                out_valid,
    input logic [BLK_BITS-1:0] out_data,
    input logic [CNT_W-1:0]    out_nbytes,
    input logic [ST_BITS-1:0]  st_cur
);
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        (st_load && !busy) |=> (st_cur == $past(st_init)));                  // R2
    AST_LOAD_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        st_load |-> !in_ready);                                              // R2
    AST_OUT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);                               // R4
    AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && in_ready));                          // R5
    AST_STATE_HELD_AT_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $stable(st_cur));                                      // R6
    AST_DEAD_LANES_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_nbytes < 5'd16) |-> ((out_data >> (8 * out_nbytes)) == '0)); // R9
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_nbytes >= 5'd1 && out_nbytes <= 5'd16));          // R9
    AST_GAP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);                               // R10
endmodule

bind aegis_stream_unit aegis_stream_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .st_load    (st_load),
    .st_init    (st_init),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_nbytes (out_nbytes),
    .st_cur     (st_cur)
);

// File: tb/aegis_stream_unit_tb.sv
module aegis_stream_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         st_load = 1'b0;
    logic [639:0] st_init = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_decrypt = 1'b0;
    logic [127:0] in_data = '0;
    logic [4:0]   in_nbytes = 5'd16;
    logic         out_valid;
    logic [127:0] out_data;
    logic [4:0]   out_nbytes;
    logic [639:0] st_cur;

    int tests = 0;
    int fails = 0;
    logic [7:0]  sb_tab [256];
    logic [31:0] seed = 32'h1234_5678;

    logic [132:0] exp_q [$];
    string        tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    aegis_stream_unit u_dut (
        .clk(clk), .rst(rst), .st_load(st_load), .st_init(st_init),
        .in_valid(in_valid), .in_ready(in_ready), .in_decrypt(in_decrypt),
        .in_data(in_data), .in_nbytes(in_nbytes), .out_valid(out_valid),
        .out_data(out_data), .out_nbytes(out_nbytes), .st_cur(st_cur)
    );

    task automatic chk(input logic ok, input string tag, input logic [639:0] act, input logic [639:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
        logic [15:0] prod = '0;
        for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (16'h011B << (i - 8));
        return prod[7:0];
    endfunction

    function automatic logic [127:0] ref_round(logic [127:0] w);
        logic [7:0] s [16];
        logic [7:0] t [16];
        logic [127:0] o;
        for (int k = 0; k < 16; k++) s[k] = sb_tab[w[8*k +: 8]];
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) t[4*c+r] = s[4*((c+r)%4)+r];
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                o[8*(4*c+r) +: 8] = ref_mul(t[4*c+r], 8'h02) ^ ref_mul(t[4*c+(r+1)%4], 8'h03)
                                  ^ t[4*c+(r+2)%4] ^ t[4*c+(r+3)%4];
        return o;
    endfunction

    function automatic logic [639:0] ref_update(logic [639:0] st, logic [127:0] m);
        logic [639:0] n;
        for (int i = 1; i < 5; i++)
            n[128*i +: 128] = st[128*i +: 128] ^ ref_round(st[128*(i-1) +: 128]);
        n[127:0] = st[127:0] ^ ref_round(st[639:512]) ^ m;
        return n;
    endfunction

    function automatic logic [127:0] ref_ks(logic [639:0] st);
        return st[255:128] ^ (st[383:256] & st[511:384]) ^ st[639:512];
    endfunction

    function automatic logic [127:0] ref_mask(int n);
        logic [127:0] m = '0;
        for (int k = 0; k < 16; k++) if (k < n) m[8*k +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [7:0] rnd8();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed[31:24];
    endfunction

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected output", {507'd0, out_nbytes, out_data}, '0);
            end else begin
                logic [132:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({out_nbytes, out_data} == e, t, {507'd0, out_nbytes, out_data}, {507'd0, e});
            end
        end
    end

    task automatic load_state(input logic [639:0] s);
        @(negedge clk);
        st_load = 1'b1;
        st_init = s;
        @(negedge clk);
        chk(st_cur == s, "R2 state load", st_cur, s);
        chk(in_ready == 1'b0, "R2 ready low during load", {639'd0, in_ready}, '0);
        st_load = 1'b0;
    endtask

    task automatic drive_blk(input logic dec, input logic [127:0] d, input logic [4:0] n,
                             input logic [132:0] exp, input string tag);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        in_valid   = 1'b1;
        in_decrypt = dec;
        in_data    = d;
        in_nbytes  = n;
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R10 ready low after accept", {639'd0, in_ready}, '0);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
    endtask

    // R11 round trip with garbage in dead lanes (R7, R8)
    task automatic round_trip(input int len, input logic [639:0] s0);
        logic [7:0]   pt [48];
        logic [7:0]   ct [48];
        logic [639:0] st_m;
        logic [639:0] st_enc;
        for (int i = 0; i < len; i++) pt[i] = rnd8();
        load_state(s0);
        st_m = s0;
        for (int off = 0; off < len; off += 16) begin
            int n = (len - off < 16) ? len - off : 16;
            logic [127:0] d, mk, ks, exp;
            for (int k = 0; k < 16; k++) d[8*k +: 8] = (k < n) ? pt[off+k] : (8'hA5 ^ 8'(k));
            mk  = ref_mask(n);
            ks  = ref_ks(st_m);
            exp = (d ^ ks) & mk;
            for (int k = 0; k < n; k++) ct[off+k] = exp[8*k +: 8];
            drive_blk(1'b0, d, 5'(n), {5'(n), exp}, $sformatf("R4 R7 encrypt len=%0d off=%0d", len, off));
            st_m = ref_update(st_m, d & mk);
        end
        wait_idle();
        chk(st_cur == st_m, $sformatf("R6 R7 state after encrypt len=%0d", len), st_cur, st_m);
        st_enc = st_m;
        load_state(s0);
        st_m = s0;
        for (int off = 0; off < len; off += 16) begin
            int n = (len - off < 16) ? len - off : 16;
            logic [127:0] d, p;
            for (int k = 0; k < 16; k++) begin
                d[8*k +: 8] = (k < n) ? ct[off+k] : (8'h3C + 8'(k));
                p[8*k +: 8] = (k < n) ? pt[off+k] : 8'h00;
            end
            drive_blk(1'b1, d, 5'(n), {5'(n), p}, $sformatf("R5 R8 R11 decrypt len=%0d off=%0d", len, off));
            st_m = ref_update(st_m, p);
        end
        wait_idle();
        chk(st_cur == st_enc, $sformatf("R11 state match len=%0d", len), st_cur, st_enc);
    endtask

    initial begin
        logic [639:0] s0;
        for (int a = 0; a < 256; a++) begin
            logic [7:0] inv = 8'h00;
            for (int b = 1; b < 256; b++) if (ref_mul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
            sb_tab[a] = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                      ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
        end
        for (int i = 0; i < 80; i++) s0[8*i +: 8] = rnd8();

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", {639'd0, out_valid}, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready after reset", {639'd0, in_ready}, 640'd1);
        chk(st_cur == '0, "R1 state zero after reset", st_cur, '0);
        chk(out_valid == 1'b0, "R1 no output after reset", {639'd0, out_valid}, '0);

        // R3: state with w1 only nonzero, zero input gives w1 as output
        begin
            logic [639:0] sk;
            logic [127:0] w1 = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
            sk = {128'd0, 128'd0, 128'd0, w1, 128'd0};
            load_state(sk);
            drive_blk(1'b0, '0, 5'd16, {5'd16, w1}, "R3 keystream is w1");
            wait_idle();
            chk(st_cur == ref_update(sk, '0), "R6 update zero message", st_cur, ref_update(sk, '0));
            sk = {128'hFFFF0000FFFF0000FFFF0000FFFF0000, 128'h00FF00FF00FF00FF00FF00FF00FF00FF,
                  128'h0F0F0F0F0F0F0F0F0F0F0F0F0F0F0F0F, 128'd0, 128'd0};
            load_state(sk);
            drive_blk(1'b1, '0, 5'd16, {5'd16, ref_ks(sk)}, "R3 nonlinear keystream");
            wait_idle();
        end

        // R9: count of 0 and of 20 act as 16
        load_state(s0);
        drive_blk(1'b0, {16{8'h5A}}, 5'd0, {5'd16, {16{8'h5A}} ^ ref_ks(s0)}, "R9 count zero as 16");
        wait_idle();
        chk(st_cur == ref_update(s0, {16{8'h5A}}), "R9 count zero absorbs all", st_cur, ref_update(s0, {16{8'h5A}}));
        load_state(s0);
        drive_blk(1'b1, {16{8'hC3}}, 5'd20, {5'd16, {16{8'hC3}} ^ ref_ks(s0)}, "R9 count 20 as 16");
        wait_idle();

        for (int len = 1; len <= 48; len++) round_trip(len, s0);

        wait_idle();
        chk(exp_q.size() == 0, "R4 all outputs seen", 640'(exp_q.size()), '0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule